// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the control and status register file of a processor core module. It sits on a simple single-cycle 32-bit bus: a request with a byte address, a write enable and write data. Read data and an error flag come back registered in the cycle after the request. The register index is the byte address divided by four. Addresses that are not multiples of four are rejected.

The block has four kinds of storage. Oscillator settings can only be written after a 16-bit key is loaded into the lock register. A control register drives a boot remap select and a status LED, and can request a board reset. Volatile and non-volatile flag words are changed through separate set and clear addresses, and so are the two interrupt enable masks. A one-bit software interrupt source, qualified by either enable mask, drives a single interrupt output.

A 64-word read-only window returns bytes of a memory presence-detect table. The table's size byte follows a configuration input that gives the installed memory in MiB.

Top module: `cm_sysctl`

## Requirements
- R1: After reset, word 0 reads 0x01000048, word 7 reads 0x0007FEFF, word 8 reads 0x00011122, word 9 reads 0x00000112 and word 3 reads 0x00000005. At the same time remap_o=1, led_o=0, irq_o=0 and board_rst_o=0. Words 8 and 9 read back the last value written to them.
- R2: A write to word 5 stores wdata[15:0] as the key. A read of word 5 returns the key in bits 15:0, with bit 16 set while the key equals 0xA05F.
- R3: Writes to words 0 and 7 update those registers only while the key equals 0xA05F. Otherwise the registers keep their values.
- R4: A write of value v to word 3 sets the stored control value to (old & ~5) | (v ^ 5). Word 3 reads the stored value. remap_o is stored bit 2, so remap is active when the written bit 2 is zero. led_o equals the written bit 0.
- R5: A write to word 3 with bit 3 set raises board_rst_o for exactly the one cycle after the write.
- R6: Word 12 ORs write data into the flags word and word 13 clears the bits that are set in the write data. Words 14 and 15 do the same for the non-volatile flags. Words 12 and 14 read the current values.
- R7: Word 18 sets and word 19 clears bits of the IRQ enable mask. Word 26 sets and word 27 clears bits of the FIQ enable mask. Words 18 and 26 read the masks.
- R8: Writes to words 20 and 21 set and clear the software level using only wdata[0]. Words 17, 25 and 20 read the level in bit 0. Word 16 reads the level ANDed with the IRQ mask and word 24 reads the level ANDed with the FIQ mask.
- R9: irq_o is high exactly when the level is set and bit 0 of the IRQ mask or of the FIQ mask is set.
- R10: A read at byte address 0x100+4k (k from 0 to 63) returns table byte k in bits 7:0. Byte 0 is 128, byte 1 is 8, byte 9 is 0xA0, byte 63 is 0. Byte 31 is 64 for mem_mib_i ≥ 256, 32 for ≥ 128, 16 for ≥ 64, 4 for ≥ 32, and 2 otherwise.
- R11: Words 32 to 35 read as zero without error and ignore writes.
- R12: A read of a non-readable word, a write to a non-writable word (status words, the table window), an address at or beyond 0x200 outside the listed words, or a misaligned address gives err_o=1 and rdata_o=0. Every other access gives err_o=0. rdata_o and err_o change only in the cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_mib_i | input | MIB_W | Installed memory size in MiB |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a request |
| err_o | output | 1 | Access error, valid the cycle after a request |
| remap_o | output | 1 | Boot memory remap select |
| led_o | output | 1 | Status LED |
| board_rst_o | output | 1 | One-cycle board reset request |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench checks that the key really gates the oscillator writes and that clearing the key locks them again. A design without the gate would let a locked write land in the oscillator register. It works through the XOR update of the control register with values that both keep and flip bit 0 and bit 2. A design that stored the value plainly, or inverted the LED, would show the wrong remap or LED state. It also checks that the soft-clear address ignores every bit but bit 0, and that irq_o follows bit 0 of either mask. Finally it reads the size byte at each memory threshold and on both sides of it, where an off-by-one comparison would return the wrong code.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned W_OSC      = 0;
  localparam int unsigned W_CTRL     = 3;
  localparam int unsigned W_LOCK     = 5;
  localparam int unsigned W_AUX      = 7;
  localparam int unsigned W_SDRAM    = 8;
  localparam int unsigned W_INIT     = 9;
  localparam int unsigned W_FLG_SET  = 12;
  localparam int unsigned W_FLG_CLR  = 13;
  localparam int unsigned W_NVF_SET  = 14;
  localparam int unsigned W_NVF_CLR  = 15;
  localparam int unsigned W_IRQ_STAT = 16;
  localparam int unsigned W_IRQ_RAW  = 17;
  localparam int unsigned W_IRQ_ENS  = 18;
  localparam int unsigned W_IRQ_ENC  = 19;
  localparam int unsigned W_SOFT_SET = 20;
  localparam int unsigned W_SOFT_CLR = 21;
  localparam int unsigned W_FIQ_STAT = 24;
  localparam int unsigned W_FIQ_RAW  = 25;
  localparam int unsigned W_FIQ_ENS  = 26;
  localparam int unsigned W_FIQ_ENC  = 27;
  localparam int unsigned W_VOLT0    = 32;
  localparam int unsigned W_VOLT1    = 33;
  localparam int unsigned W_VOLT2    = 34;
  localparam int unsigned W_VOLT3    = 35;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam int unsigned PD_IDX_W   = 6;
  localparam int unsigned PD_SIZE_IX = 31;

  // fixed part of the presence-detect table; unlisted entries are zero
  function automatic logic [7:0] pd_base(input logic [PD_IDX_W-1:0] idx);
    case (idx)
      6'd0:  pd_base = 8'd128;
      6'd1:  pd_base = 8'd8;
      6'd2:  pd_base = 8'd4;
      6'd3:  pd_base = 8'd11;
      6'd4:  pd_base = 8'd9;
      6'd5:  pd_base = 8'd1;
      6'd6:  pd_base = 8'd64;
      6'd8:  pd_base = 8'd2;
      6'd9:  pd_base = 8'hA0;
      6'd10: pd_base = 8'hA0;
      6'd13: pd_base = 8'd8;
      6'd15: pd_base = 8'd1;
      6'd16: pd_base = 8'h0E;
      6'd17: pd_base = 8'd4;
      6'd18: pd_base = 8'h1C;
      6'd19: pd_base = 8'd1;
      6'd20: pd_base = 8'd2;
      6'd21: pd_base = 8'h20;
      6'd22: pd_base = 8'hC0;
      6'd27: pd_base = 8'h30;
      6'd28: pd_base = 8'h28;
      6'd29: pd_base = 8'h30;
      6'd30: pd_base = 8'h28;
      default: pd_base = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST;
    else if (set_i) q_o <= q_o | d_i;
    else if (clr_i) q_o <= q_o & ~d_i;
  end
endmodule

// File: rtl/cm_osc_lock.sv
module cm_osc_lock
  import cm_sysctl_pkg::*;
#(
  parameter logic [DW-1:0] OSC_RST = 32'h0100_0048,
  parameter logic [DW-1:0] AUX_RST = 32'h0007_FEFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_osc_i,
  input  logic          wr_aux_i,
  input  logic          wr_key_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] osc_o,
  output logic [DW-1:0] aux_o,
  output logic [15:0]   key_o,
  output logic          unlocked_o
);
  assign unlocked_o = (key_o == UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_o <= OSC_RST;
      aux_o <= AUX_RST;
      key_o <= '0;
    end else begin
      if (wr_key_i)               key_o <= d_i[15:0];
      if (wr_osc_i && unlocked_o) osc_o <= d_i;
      if (wr_aux_i && unlocked_o) aux_o <= d_i;
    end
  end
endmodule

// File: rtl/cm_pd_rom.sv
module cm_pd_rom
  import cm_sysctl_pkg::*;
#(
  parameter int unsigned MIB_W = 16
) (
  input  logic [PD_IDX_W-1:0] idx_i,
  input  logic [MIB_W-1:0]    mib_i,
  output logic [7:0]          byte_o
);
  logic [31:0] mib_w;
  logic [7:0]  size_b;

  assign mib_w = 32'(mib_i);

  always_comb begin
    if      (mib_w >= 32'd256) size_b = 8'd64;
    else if (mib_w >= 32'd128) size_b = 8'd32;
    else if (mib_w >= 32'd64)  size_b = 8'd16;
    else if (mib_w >= 32'd32)  size_b = 8'd4;
    else                       size_b = 8'd2;
  end

  assign byte_o = (idx_i == PD_IDX_W'(PD_SIZE_IX)) ? size_b : pd_base(idx_i);
endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
  import cm_sysctl_pkg::*;
#(
  parameter int unsigned   AW        = 12,
  parameter int unsigned   MIB_W     = 16,
  parameter logic [DW-1:0] OSC_RST   = 32'h0100_0048,
  parameter logic [DW-1:0] AUX_RST   = 32'h0007_FEFF,
  parameter logic [DW-1:0] SDRAM_RST = 32'h0001_1122,
  parameter logic [DW-1:0] INIT_RST  = 32'h0000_0112,
  parameter logic [DW-1:0] CTRL_RST  = 32'h0000_0005
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MIB_W-1:0] mem_mib_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             err_o,
  output logic             remap_o,
  output logic             led_o,
  output logic             board_rst_o,
  output logic             irq_o
);
  localparam logic [DW-1:0] XOR_MASK = 32'h5;
  localparam int unsigned   WIN_W    = AW - 8;

  logic [31:0]   widx;
  logic          in_win, misal, wr;
  logic          rd_ok, wr_ok, acc_ok;
  logic [DW-1:0] rd_val;

  logic [DW-1:0] osc_q, aux_q, sdram_q, init_q, ctrl_q;
  logic [15:0]   key_q;
  logic          unlocked;
  logic [DW-1:0] flags_q, nvflags_q, irq_en_q, fiq_en_q;
  logic          lvl_q;
  logic [DW-1:0] lvl_w;
  logic [7:0]    pd_byte;

  assign widx   = 32'(addr_i[AW-1:2]);
  assign in_win = (addr_i[AW-1:8] == WIN_W'(1));
  assign misal  = |addr_i[1:0];
  assign wr     = req_i && we_i && !misal && !in_win;
  assign lvl_w  = {{(DW-1){1'b0}}, lvl_q};

  function automatic logic hit(input logic [31:0] w, input int unsigned k);
    return w == 32'(k);
  endfunction

  cm_osc_lock #(.OSC_RST(OSC_RST), .AUX_RST(AUX_RST)) u_osc (
    .clk_i, .rst_ni,
    .wr_osc_i (wr && hit(widx, W_OSC)),
    .wr_aux_i (wr && hit(widx, W_AUX)),
    .wr_key_i (wr && hit(widx, W_LOCK)),
    .d_i      (wdata_i),
    .osc_o    (osc_q),
    .aux_o    (aux_q),
    .key_o    (key_q),
    .unlocked_o (unlocked)
  );

  cm_setclr_reg #(.W(DW)) u_flags (
    .clk_i, .rst_ni,
    .set_i (wr && hit(widx, W_FLG_SET)),
    .clr_i (wr && hit(widx, W_FLG_CLR)),
    .d_i (wdata_i), .q_o (flags_q)
  );

  cm_setclr_reg #(.W(DW)) u_nvflags (
    .clk_i, .rst_ni,
    .set_i (wr && hit(widx, W_NVF_SET)),
    .clr_i (wr && hit(widx, W_NVF_CLR)),
    .d_i (wdata_i), .q_o (nvflags_q)
  );

  cm_setclr_reg #(.W(DW)) u_irq_en (
    .clk_i, .rst_ni,
    .set_i (wr && hit(widx, W_IRQ_ENS)),
    .clr_i (wr && hit(widx, W_IRQ_ENC)),
    .d_i (wdata_i), .q_o (irq_en_q)
  );

  cm_setclr_reg #(.W(DW)) u_fiq_en (
    .clk_i, .rst_ni,
    .set_i (wr && hit(widx, W_FIQ_ENS)),
    .clr_i (wr && hit(widx, W_FIQ_ENC)),
    .d_i (wdata_i), .q_o (fiq_en_q)
  );

  cm_setclr_reg #(.W(1)) u_level (
    .clk_i, .rst_ni,
    .set_i (wr && hit(widx, W_SOFT_SET)),
    .clr_i (wr && hit(widx, W_SOFT_CLR)),
    .d_i (wdata_i[0]), .q_o (lvl_q)
  );

  cm_pd_rom #(.MIB_W(MIB_W)) u_pd (
    .idx_i (addr_i[7:2]), .mib_i (mem_mib_i), .byte_o (pd_byte)
  );

  always_comb begin
    rd_ok  = 1'b1;
    rd_val = '0;
    if (in_win) rd_val = {24'b0, pd_byte};
    else begin
      case (widx)
        32'(W_OSC):      rd_val = osc_q;
        32'(W_CTRL):     rd_val = ctrl_q;
        32'(W_LOCK):     rd_val = {15'b0, unlocked, key_q};
        32'(W_AUX):      rd_val = aux_q;
        32'(W_SDRAM):    rd_val = sdram_q;
        32'(W_INIT):     rd_val = init_q;
        32'(W_FLG_SET):  rd_val = flags_q;
        32'(W_NVF_SET):  rd_val = nvflags_q;
        32'(W_IRQ_STAT): rd_val = lvl_w & irq_en_q;
        32'(W_IRQ_RAW),
        32'(W_FIQ_RAW),
        32'(W_SOFT_SET): rd_val = lvl_w;
        32'(W_IRQ_ENS):  rd_val = irq_en_q;
        32'(W_FIQ_STAT): rd_val = lvl_w & fiq_en_q;
        32'(W_FIQ_ENS):  rd_val = fiq_en_q;
        32'(W_VOLT0), 32'(W_VOLT1),
        32'(W_VOLT2), 32'(W_VOLT3): rd_val = '0;
        default:         rd_ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    wr_ok = 1'b0;
    if (!in_win) begin
      case (widx)
        32'(W_OSC), 32'(W_CTRL), 32'(W_LOCK), 32'(W_AUX),
        32'(W_SDRAM), 32'(W_INIT),
        32'(W_FLG_SET), 32'(W_FLG_CLR), 32'(W_NVF_SET), 32'(W_NVF_CLR),
        32'(W_IRQ_ENS), 32'(W_IRQ_ENC), 32'(W_SOFT_SET), 32'(W_SOFT_CLR),
        32'(W_FIQ_ENS), 32'(W_FIQ_ENC),
        32'(W_VOLT0), 32'(W_VOLT1), 32'(W_VOLT2), 32'(W_VOLT3): wr_ok = 1'b1;
        default: wr_ok = 1'b0;
      endcase
    end
  end

  assign acc_ok = !misal && (we_i ? wr_ok : rd_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= CTRL_RST;
      sdram_q     <= SDRAM_RST;
      init_q      <= INIT_RST;
      board_rst_o <= 1'b0;
      rdata_o     <= '0;
      err_o       <= 1'b0;
    end else begin
      board_rst_o <= wr && hit(widx, W_CTRL) && wdata_i[3];
      // control bits 0 and 2 are kept inverted
      if (wr && hit(widx, W_CTRL))  ctrl_q  <= (ctrl_q & ~XOR_MASK) | (wdata_i ^ XOR_MASK);
      if (wr && hit(widx, W_SDRAM)) sdram_q <= wdata_i;
      if (wr && hit(widx, W_INIT))  init_q  <= wdata_i;
      if (req_i) begin
        rdata_o <= (acc_ok && !we_i) ? rd_val : '0;
        err_o   <= !acc_ok;
      end
    end
  end

  assign remap_o = ctrl_q[2];
  assign led_o   = ~ctrl_q[0];
  assign irq_o   = lvl_q && (irq_en_q[0] || fiq_en_q[0]);
endmodule

// File: rtl/cm_sysctl_chk.sv
module cm_sysctl_chk #(
  parameter int unsigned AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   wdata_i,
  input logic [31:0]   rdata_o,
  input logic          err_o,
  input logic          remap_o,
  input logic          board_rst_o,
  input logic [31:0]   osc_q,
  input logic          unlocked
);
  logic ctrl_wr;
  assign ctrl_wr = req_i && we_i && (addr_i == AW'(12'h00C));

  // R5
  rst_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[3]) |=> board_rst_o);

  // R5
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_rst_o |=> !board_rst_o);

  // R3
  osc_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i == AW'(0)) && !unlocked) |=> $stable(osc_q));

  // R4
  remap_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(remap_o) |-> $past(ctrl_wr));

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> ($stable(rdata_o) && $stable(err_o)));

  // R12
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(req_i));
endmodule

bind cm_sysctl cm_sysctl_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .err_o,
  .remap_o, .board_rst_o, .osc_q(osc_q), .unlocked(unlocked)
);

// File: tb/tb_cm_sysctl.sv
module tb_cm_sysctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_mib = 16'd16;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        err_o, remap_o, led_o, board_rst_o, irq_o;
  int chk_cnt = 0, fail_cnt = 0;

  always #5 clk = ~clk;

  cm_sysctl dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_mib_i(mem_mib), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o, .err_o, .remap_o, .led_o,
    .board_rst_o, .irq_o
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", r, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] q, output logic e);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    q = rdata_o; e = err_o;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string r);
    logic [31:0] q; logic e;
    acc(1'b1, a, d, q, e);
    chk({r, " write err"}, 32'(e), 32'd0);
  endtask

  task automatic rchk(input logic [11:0] a, input logic [31:0] exp, input string r);
    logic [31:0] q; logic e;
    acc(1'b0, a, 32'd0, q, e);
    chk(r, q, exp);
    chk({r, " err"}, 32'(e), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 remap", 32'(remap_o), 32'd1);
    chk("R1 led", 32'(led_o), 32'd0);
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 brst", 32'(board_rst_o), 32'd0);
    rchk(12'h000, 32'h0100_0048, "R1 osc");
    rchk(12'h01C, 32'h0007_FEFF, "R1 aux");
    rchk(12'h020, 32'h0001_1122, "R1 sdram");
    rchk(12'h024, 32'h0000_0112, "R1 init");
    rchk(12'h00C, 32'h0000_0005, "R1 ctrl");
    wr(12'h020, 32'hABCD_0123, "R1");
    wr(12'h024, 32'h0000_7777, "R1");
    rchk(12'h020, 32'hABCD_0123, "R1 sdram rw");
    rchk(12'h024, 32'h0000_7777, "R1 init rw");
  endtask

  task automatic t_lock;
    wr(12'h000, 32'h1111_2222, "R3");
    rchk(12'h000, 32'h0100_0048, "R3 locked osc");
    wr(12'h014, 32'h1234_A05F, "R2");
    rchk(12'h014, 32'h0001_A05F, "R2 key unlocked");
    wr(12'h000, 32'hDEAD_0001, "R3");
    wr(12'h01C, 32'h0000_00AA, "R3");
    rchk(12'h000, 32'hDEAD_0001, "R3 osc unlocked");
    rchk(12'h01C, 32'h0000_00AA, "R3 aux unlocked");
    wr(12'h014, 32'h0000_A05E, "R2");
    rchk(12'h014, 32'h0000_A05E, "R2 key locked");
    wr(12'h000, 32'h0000_0055, "R3");
    wr(12'h01C, 32'h0000_0055, "R3");
    rchk(12'h000, 32'hDEAD_0001, "R3 osc relocked");
    rchk(12'h01C, 32'h0000_00AA, "R3 aux relocked");
  endtask

  task automatic t_ctrl;
    wr(12'h00C, 32'h0, "R4");
    chk("R4 remap w0", 32'(remap_o), 32'd1);
    chk("R4 led w0", 32'(led_o), 32'd0);
    wr(12'h00C, 32'h1, "R4");
    chk("R4 led w1", 32'(led_o), 32'd1);
    chk("R4 remap w1", 32'(remap_o), 32'd1);
    wr(12'h00C, 32'h4, "R4");
    chk("R4 remap w4", 32'(remap_o), 32'd0);
    chk("R4 led w4", 32'(led_o), 32'd0);
    rchk(12'h00C, 32'h1, "R4 ctrl w4");
    wr(12'h00C, 32'h30, "R4");
    chk("R5 no brst", 32'(board_rst_o), 32'd0);
    rchk(12'h00C, 32'h35, "R4 ctrl w30");
    wr(12'h00C, 32'h08, "R5");
    chk("R5 brst high", 32'(board_rst_o), 32'd1);
    @(negedge clk);
    chk("R5 brst one cycle", 32'(board_rst_o), 32'd0);
    rchk(12'h00C, 32'h3D, "R4 ctrl w08");
    chk("R4 remap w08", 32'(remap_o), 32'd1);
  endtask

  task automatic t_flags;
    wr(12'h030, 32'hF0, "R6");
    wr(12'h030, 32'h0F, "R6");
    rchk(12'h030, 32'hFF, "R6 flags set");
    wr(12'h034, 32'h3C, "R6");
    rchk(12'h030, 32'hC3, "R6 flags clr");
    wr(12'h038, 32'hA5A5, "R6");
    wr(12'h03C, 32'h00A0, "R6");
    rchk(12'h038, 32'hA505, "R6 nvflags");
    rchk(12'h030, 32'hC3, "R6 flags untouched");
  endtask

  task automatic t_irq;
    wr(12'h048, 32'h3, "R7");
    rchk(12'h048, 32'h3, "R7 irq en");
    chk("R9 no level", 32'(irq_o), 32'd0);
    wr(12'h050, 32'hFFFF_FFFF, "R8");
    rchk(12'h044, 32'h1, "R8 raw");
    rchk(12'h040, 32'h1, "R8 irq stat");
    rchk(12'h050, 32'h1, "R8 soft read");
    chk("R9 irq on", 32'(irq_o), 32'd1);
    wr(12'h068, 32'h6, "R7");
    rchk(12'h068, 32'h6, "R7 fiq en");
    rchk(12'h060, 32'h0, "R8 fiq stat masked");
    wr(12'h04C, 32'h1, "R7");
    rchk(12'h048, 32'h2, "R7 irq en clr");
    chk("R9 both masked", 32'(irq_o), 32'd0);
    wr(12'h068, 32'h1, "R7");
    chk("R9 via fiq", 32'(irq_o), 32'd1);
    rchk(12'h060, 32'h1, "R8 fiq stat");
    rchk(12'h064, 32'h1, "R8 fiq raw");
    wr(12'h054, 32'hFFFF_FFFE, "R8");
    chk("R8 clr ignores upper", 32'(irq_o), 32'd1);
    rchk(12'h044, 32'h1, "R8 raw kept");
    wr(12'h054, 32'h1, "R8");
    chk("R9 level cleared", 32'(irq_o), 32'd0);
    rchk(12'h044, 32'h0, "R8 raw cleared");
    wr(12'h06C, 32'h7, "R7");
    rchk(12'h068, 32'h0, "R7 fiq en clr");
  endtask

  task automatic t_pd;
    rchk(12'h100, 32'd128, "R10 byte0");
    rchk(12'h104, 32'd8, "R10 byte1");
    rchk(12'h124, 32'hA0, "R10 byte9");
    rchk(12'h1FC, 32'h0, "R10 byte63");
    mem_mib = 16'd31;  rchk(12'h17C, 32'd2, "R10 size 31");
    mem_mib = 16'd32;  rchk(12'h17C, 32'd4, "R10 size 32");
    mem_mib = 16'd63;  rchk(12'h17C, 32'd4, "R10 size 63");
    mem_mib = 16'd64;  rchk(12'h17C, 32'd16, "R10 size 64");
    mem_mib = 16'd127; rchk(12'h17C, 32'd16, "R10 size 127");
    mem_mib = 16'd128; rchk(12'h17C, 32'd32, "R10 size 128");
    mem_mib = 16'd255; rchk(12'h17C, 32'd32, "R10 size 255");
    mem_mib = 16'd256; rchk(12'h17C, 32'd64, "R10 size 256");
  endtask

  task automatic t_volt;
    rchk(12'h080, 32'h0, "R11 volt read");
    wr(12'h084, 32'hFFFF_FFFF, "R11");
    rchk(12'h084, 32'h0, "R11 volt write ignored");
    rchk(12'h08C, 32'h0, "R11 volt last");
  endtask

  task automatic t_err;
    logic [31:0] q; logic e;
    acc(1'b0, 12'h004, 32'h0, q, e);
    chk("R12 err word1", 32'(e), 32'd1);
    chk("R12 data word1", q, 32'h0);
    rchk(12'h030, 32'hC3, "R12 err cleared");
    acc(1'b1, 12'h040, 32'hFFFF_FFFF, q, e);
    chk("R12 err wr status", 32'(e), 32'd1);
    acc(1'b1, 12'h100, 32'h0, q, e);
    chk("R12 err wr window", 32'(e), 32'd1);
    acc(1'b0, 12'h034, 32'h0, q, e);
    chk("R12 err rd clr word", 32'(e), 32'd1);
    acc(1'b0, 12'h200, 32'h0, q, e);
    chk("R12 err high addr", 32'(e), 32'd1);
    acc(1'b0, 12'h032, 32'h0, q, e);
    chk("R12 err misaligned", 32'(e), 32'd1);
    chk("R12 data misaligned", q, 32'h0);
    repeat (2) @(negedge clk);
    chk("R12 err held", 32'(err_o), 32'd1);
    rchk(12'h040, 32'h0, "R12 status no write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_ctrl();
    t_flags();
    t_irq();
    t_pd();
    t_volt();
    t_err();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    #2_000_000;
    chk_cnt++;
    fail_cnt++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end
endmodule